// File: doc/BRIEF.md
# Signed Two's Complement Array Multiplier

This block multiplies two signed operands of N bits each and returns their full 2N-bit signed product. It builds the product from single-bit AND terms. The terms that involve exactly one sign bit enter the array inverted. Two constant ones are injected into the array, so none of the rows needs sign extension. The rows are then summed by a ripple array of full adders, one adder chain per row.

The array itself is pure logic. A parameter selects whether the result leaves directly or through one output register. That register is cleared by a synchronous reset. With the register in place, a product is available one clock after its operands are captured.

Top module: `bw_mult`

## Requirements
- R1: For every pair of N-bit two's complement operands x and y, z equals the signed product x*y as a 2N-bit two's complement value. Any carry beyond bit 2N-1 is dropped.
- R2: If either operand is zero, z is all zeros.
- R3: If both operands are nonzero, bit 2N-1 of z is 1 exactly when the operand sign bits differ.
- R4: The most negative operand multiplied by itself gives +2^(2N-2) without overflow. For N=4 this is 8'h40.
- R5: Multiplying by -1 (all ones) gives the negation of the other operand. The most negative operand times -1 gives +2^(N-1), which is 8'h08 for N=4.
- R6: With REG_OUT=1, z takes the product of the operands present at a rising clock edge. It holds that value until the next edge, whatever the inputs do in between.
- R7: With REG_OUT=1, z is all zeros after any rising edge at which rst is high.
- R8: With REG_OUT=0, z follows the operands with no clock and meets R1 for a wider width (N=12).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| x | input | N | Signed multiplicand |
| y | input | N | Signed multiplier |
| z | output | 2N | Signed product |

## Verification
The assertions assume that x and y are stable and fully defined at every rising edge while reset is low. They also assume the register variant is in use, because that is where the checks live. The bench changes the operands only at falling edges, so every captured pair is settled well before it is sampled. For the wide combinational instance, it samples the result after a short settle delay. Reset is held from time zero until the first operands are applied, so no property sees an undriven operand.

// File: rtl/bw_mult.sv
module bw_mult #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [N-1:0]   x,
  input  logic signed [N-1:0]   y,
  output logic signed [2*N-1:0] z
);
  localparam int W = 2 * N;
  localparam logic [W-1:0] BIAS = (W'(1) << N) | (W'(1) << (W - 1));

  logic [N:0][W-1:0]   acc;
  logic [N-1:0][W-1:0] pp;
  logic [N-1:0][W-1:0] cy;

  assign acc[0] = BIAS;

  for (genvar j = 0; j < N; j++) begin : g_row
    for (genvar k = 0; k < W; k++) begin : g_col
      if (k >= j && k - j < N) begin : g_term
        localparam int I = k - j;
        localparam bit INV = (I == N - 1) != (j == N - 1);
        assign pp[j][k] = (x[I] & y[j]) ^ INV;
      end else begin : g_zero
        assign pp[j][k] = 1'b0;
      end
      assign acc[j+1][k] = acc[j][k] ^ pp[j][k] ^ cy[j][k];
      if (k < W - 1) begin : g_cy
        assign cy[j][k+1] = (acc[j][k] & pp[j][k]) | (acc[j][k] & cy[j][k]) |
                            (pp[j][k] & cy[j][k]);
      end
    end
    assign cy[j][0] = 1'b0;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) z <= '0;
      else     z <= acc[N];
    end

    logic signed [W-1:0] xs, ys, ref_p;
    assign xs    = x;
    assign ys    = y;
    assign ref_p = xs * ys;

    // R1 R6
    product_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> z == $past(ref_p));

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> z == '0);

    // R2
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(x == '0 || y == '0)) |-> z == '0);

    // R3
    sign_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(x != '0 && y != '0)) |-> z[W-1] == $past(x[N-1] ^ y[N-1]));

    // R4
    min_square_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(x == {1'b1, {(N-1){1'b0}}} && y == {1'b1, {(N-1){1'b0}}}))
      |-> z == (W'(1) << (W - 2)));
  end else begin : g_comb
    assign z = acc[N];
  end
endmodule

// File: tb/bw_mult_tb.sv
module bw_mult_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] a = '0, b = '0;
  logic [7:0] z;
  logic [NW-1:0] aw = '0, bw = '0;
  logic [2*NW-1:0] zw;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bw_mult #(.N(4), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .x(a), .y(b), .z(z));

  bw_mult #(.N(NW), .REG_OUT(1'b0)) u_dut_comb (
    .clk(clk), .rst(rst), .x(aw), .y(bw), .z(zw));

  // {a, b, expected product}
  localparam logic [15:0] VEC [9] = '{
    {4'h7, 4'h7, 8'h31},  // R1  7*7
    {4'h8, 4'h8, 8'h40},  // R4  -8*-8
    {4'h8, 4'hF, 8'h08},  // R5  -8*-1
    {4'hF, 4'hF, 8'h01},  // R5  -1*-1
    {4'h7, 4'h8, 8'hC8},  // R3  7*-8
    {4'h0, 4'h8, 8'h00},  // R2  0*-8
    {4'h5, 4'h0, 8'h00},  // R2  5*0
    {4'hF, 4'h3, 8'hFD},  // R5  -1*3
    {4'h3, 4'hA, 8'hEE}   // R3  3*-6
  };
  localparam string TAG [9] = '{"R1", "R4", "R5", "R5", "R3", "R2", "R2", "R5", "R3"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] prod4(input logic [3:0] p, input logic [3:0] q);
    logic signed [7:0] e;
    e = $signed(p) * $signed(q);
    return e;
  endfunction

  function automatic logic [2*NW-1:0] prodw(input logic [NW-1:0] p, input logic [NW-1:0] q);
    logic signed [2*NW-1:0] e;
    e = $signed(p) * $signed(q);
    return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R7: reset holds the register at zero while operands are applied
    a = 4'h3; b = 4'h3;
    repeat (3) @(negedge clk);
    chk("R7", 32'(z), 32'h0);
    rst = 1'b0;

    // directed table
    for (int i = 0; i < 9; i++) begin
      a = VEC[i][15:12];
      b = VEC[i][11:8];
      @(negedge clk);
      chk(TAG[i], 32'(z), 32'(VEC[i][7:0]));
    end

    // R6: new operands between edges leave z unchanged until the next edge
    a = 4'h6; b = 4'h2;
    @(negedge clk);
    chk("R6", 32'(z), 32'h0C);
    a = 4'h9; b = 4'h5;
    #1;
    chk("R6", 32'(z), 32'h0C);
    @(negedge clk);
    chk("R6", 32'(z), 32'(prod4(4'h9, 4'h5)));

    // R1: exhaustive over all operand pairs
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 16; k++) begin
        a = 4'(i); b = 4'(k);
        @(negedge clk);
        chk("R1", 32'(z), 32'(prod4(4'(i), 4'(k))));
      end
    end

    // R7: synchronous reset in mid-run clears the register
    a = 4'h7; b = 4'h7;
    rst = 1'b1;
    @(negedge clk);
    chk("R7", 32'(z), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7", 32'(z), 32'h31);

    // R8: wide combinational variant, corners then random
    aw = {1'b1, {(NW-1){1'b0}}}; bw = aw;
    #1;
    chk("R8", 32'(zw), 32'(24'd1 << (2*NW-2)));
    aw = '1; bw = {1'b1, {(NW-1){1'b0}}};
    #1;
    chk("R8", 32'(zw), 32'(24'd1 << (NW-1)));
    aw = '0; bw = 12'h5A5;
    #1;
    chk("R8", 32'(zw), 32'h0);
    for (int i = 0; i < 300; i++) begin
      aw = NW'($urandom);
      bw = NW'($urandom);
      #1;
      chk("R8", 32'(zw), 32'(prodw(aw, bw)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule